// File: doc/BRIEF.md
# ADC Result Window Comparator

This block sits beside an analog-to-digital converter and decides, for every finished conversion, whether the conversion-complete interrupt is raised. Software programs an upper and a lower 8-bit limit and picks one of two window modes. In the first mode a result inside the limits raises the interrupt. In the second mode a result outside the limits raises it. When the converter runs at 12-bit resolution, only the eight most significant result bits are compared. At 8-bit resolution the whole result is compared.

The limits may only change while the converter is idle. A limit write that arrives while the converter's start or enable status is high is dropped. That dropped write sets a sticky error flag, and software clears the flag by reading it. The comparison is registered, so the interrupt is a single-clock pulse in the cycle after the conversion-done strobe.

Top module: `adc_window_cmp`

## Requirements
- R1: After reset the upper limit reads 0xFF, the lower limit reads 0x00, the mode bit reads 0, the error flag reads 0 and `irq_pulse` is low.
- R2: The register map is: address 0 holds the upper limit, address 1 holds the lower limit, address 2 holds the mode in bit 0, and address 3 holds the error flag in bit 0. Unused bits read 0. A write to address 0 or 1 while `conv_start` and `conv_enable` are both 0 updates that limit, and the new value reads back.
- R3: A write to address 0 or 1 while `conv_start` or `conv_enable` is 1 leaves that limit unchanged.
- R4: A write refused under R3 sets the error flag. The flag stays set until a read of address 3, which returns 1; the next read returns 0 unless a new write has been refused in the meantime.
- R5: With `res_12b` = 1, the value compared with the limits is `conv_result[11:4]`.
- R6: With `res_12b` = 0, the value compared with the limits is `conv_result[7:0]`.
- R7: With mode 0, a conversion raises the interrupt when lower ≤ value ≤ upper. The comparison is unsigned and both bounds are inclusive.
- R8: With mode 1, a conversion raises the interrupt when value < lower or value > upper.
- R9: `irq_pulse` is high for exactly the one clock after a clock edge that samples `conv_done` high with a hit, and it is low at every other time.
- R10: If the upper limit is below the lower limit, both inequalities are still applied as written. Mode 0 then never fires, and mode 1 fires for any value below the lower limit or above the upper limit.
- R11: Writes to the mode register at address 2 take effect at any time, including while the converter is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of the status register clears it) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| conv_start | input | 1 | Converter start status |
| conv_enable | input | 1 | Converter enable status |
| conv_done | input | 1 | Conversion-complete strobe |
| conv_result | input | 12 | Conversion result (in 8-bit mode the low byte is used) |
| res_12b | input | 1 | 1 selects 12-bit resolution, 0 selects 8-bit resolution |
| irq_pulse | output | 1 | One-clock conversion interrupt |

## Verification
A corrupted limit or mode value shows up through two paths. It reads back wrongly at once, and it changes `irq_pulse` on the first conversion whose compared value falls between the true limit and the corrupted one. The bench therefore aims many results at the limits and one code either side of them. An error flag stuck low or stuck high shows up on the first status read after a refused write, or on a second read of address 3. A wrong pipeline depth shifts the interrupt by a cycle or stretches it, so the bench samples `irq_pulse` both in the cycle after the strobe and in the cycle after that.

// File: rtl/adcwin_pkg.sv
// Package: shared widths and register addresses for the window comparator.
// Assumes a 2-bit register address space with four byte-wide registers.
package adcwin_pkg;
    localparam int unsigned LIM_W  = 8;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_UPPER  = 2'd0,
        A_LOWER  = 2'd1,
        A_MODE   = 2'd2,
        A_STATUS = 2'd3
    } reg_addr_e;

    typedef enum logic {
        WIN_INSIDE  = 1'b0,
        WIN_OUTSIDE = 1'b1
    } win_mode_e;
endpackage

// File: rtl/adcwin_regs.sv
// Module: adcwin_regs
// Holds the two limit registers, the mode bit and the sticky write-error flag.
// Limit writes are refused while the converter is busy. Reading the status
// register clears the error flag, but a refusal in the same cycle takes priority.
// Assumes the reg_wr and reg_rd strobes are synchronous to clk.
module adcwin_regs
    import adcwin_pkg::*;
#(
    parameter int unsigned W       = LIM_W,
    parameter logic [W-1:0] UP_RST = '1,
    parameter logic [W-1:0] LO_RST = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [W-1:0]        reg_wdata,
    input  logic                busy,
    output logic [W-1:0]        reg_rdata,
    output logic [W-1:0]        upper_lim,
    output logic [W-1:0]        lower_lim,
    output win_mode_e           mode,
    output logic                wr_err
);
    localparam logic [W-1:0] ZERO = '0;

    logic lim_sel;
    logic refuse;

    // Decode a limit access and decide whether it must be refused.
    always_comb begin
        lim_sel = (reg_addr == A_UPPER) || (reg_addr == A_LOWER);
        refuse  = reg_wr && lim_sel && busy;
    end

    // Limit registers: updated only by accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_lim <= UP_RST;
            lower_lim <= LO_RST;
        end else if (reg_wr && !busy) begin
            if (reg_addr == A_UPPER) upper_lim <= reg_wdata;
            if (reg_addr == A_LOWER) lower_lim <= reg_wdata;
        end
    end

    // Mode bit: writable regardless of converter state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= WIN_INSIDE;
        else if (reg_wr && reg_addr == A_MODE)
            mode <= win_mode_e'(reg_wdata[0]);
    end

    // Sticky error flag: set by a refusal, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_err <= 1'b0;
        else if (refuse)
            wr_err <= 1'b1;
        else if (reg_rd && reg_addr == A_STATUS)
            wr_err <= 1'b0;
    end

    // Read-data multiplexer.
    always_comb begin
        unique case (reg_addr)
            A_UPPER:  reg_rdata = upper_lim;
            A_LOWER:  reg_rdata = lower_lim;
            A_MODE:   reg_rdata = {ZERO[W-1:1], mode};
            default:  reg_rdata = {ZERO[W-1:1], wr_err};
        endcase
    end
endmodule

// File: rtl/adcwin_select.sv
// Module: adcwin_select
// Picks the byte of the conversion result that is compared with the limits:
// the top W bits at full resolution, or the low W bits at reduced resolution.
// Assumes RES_W >= W.
module adcwin_select #(
    parameter int unsigned RES_W = 12,
    parameter int unsigned W     = 8
) (
    input  logic [RES_W-1:0] result,
    input  logic             full_res,
    output logic [W-1:0]     cmp_val
);
    localparam int unsigned TOP = RES_W - 1;

    // Resolution-dependent byte selection.
    always_comb begin
        cmp_val = full_res ? result[TOP -: W] : result[W-1:0];
    end
endmodule

// File: rtl/adcwin_judge.sv
// Module: adcwin_judge
// Applies the window test to the compared value and registers the outcome,
// gated by the done strobe, into a one-clock interrupt.
// Assumes the limits are stable in the strobe cycle. No correction is made
// when the limits are inverted.
module adcwin_judge
    import adcwin_pkg::*;
#(
    parameter int unsigned W = LIM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         done,
    input  logic [W-1:0] val,
    input  logic [W-1:0] upper_lim,
    input  logic [W-1:0] lower_lim,
    input  win_mode_e    mode,
    output logic         irq
);
    logic in_win;
    logic hit;

    // Window test on the compared value.
    always_comb begin
        in_win = (val >= lower_lim) && (val <= upper_lim);
        if (mode == WIN_OUTSIDE)
            hit = (val < lower_lim) || (val > upper_lim);
        else
            hit = in_win;
    end

    // Registered interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= done && hit;
    end
endmodule

// File: rtl/adc_window_cmp.sv
// Module: adc_window_cmp (top)
// Decides whether each finished conversion raises the interrupt, using
// programmable limits and a window mode. The converter counts as busy while
// its start or its enable status is high.
module adc_window_cmp
    import adcwin_pkg::*;
#(
    parameter int unsigned RES_W = 12,
    parameter int unsigned W     = LIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic              conv_start,
    input  logic              conv_enable,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              res_12b,
    output logic              irq_pulse
);
    logic [W-1:0] upper_lim;
    logic [W-1:0] lower_lim;
    logic [W-1:0] cmp_val;
    win_mode_e    mode;
    logic         wr_err;
    logic         busy;

    // Converter busy status.
    always_comb busy = conv_start || conv_enable;

    adcwin_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy),
        .reg_rdata(reg_rdata), .upper_lim(upper_lim), .lower_lim(lower_lim),
        .mode(mode), .wr_err(wr_err)
    );

    adcwin_select #(.RES_W(RES_W), .W(W)) u_sel (
        .result(conv_result), .full_res(res_12b), .cmp_val(cmp_val)
    );

    adcwin_judge #(.W(W)) u_judge (
        .clk(clk), .rst_n(rst_n), .done(conv_done), .val(cmp_val),
        .upper_lim(upper_lim), .lower_lim(lower_lim), .mode(mode),
        .irq(irq_pulse)
    );
endmodule

// File: rtl/adc_window_cmp_chk.sv
// Module: adc_window_cmp_chk
// Temporal checks on the window comparator, attached to the top by bind.
module adc_window_cmp_chk #(
    parameter int unsigned RES_W = 12,
    parameter int unsigned W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [1:0]       reg_addr,
    input logic             conv_start,
    input logic             conv_enable,
    input logic             conv_done,
    input logic [RES_W-1:0] conv_result,
    input logic             res_12b,
    input logic             irq_pulse,
    input logic [W-1:0]     upper_lim,
    input logic [W-1:0]     lower_lim,
    input logic             mode,
    input logic             wr_err
);
    // R3
    limits_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start || conv_enable) |=> ($stable(upper_lim) && $stable(lower_lim)));

    // R4
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[1] == 1'b0 && (conv_start || conv_enable)) |=> wr_err);

    // R4
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd3 && !(reg_wr && reg_addr[1] == 1'b0)) |=> !wr_err);

    // R9
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(conv_done));

    // R5
    top_byte_at_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && res_12b && !mode && lower_lim <= upper_lim &&
         conv_result[RES_W-1 -: W] == upper_lim) |=> irq_pulse);
endmodule

bind adc_window_cmp adc_window_cmp_chk #(.RES_W(RES_W), .W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .conv_start(conv_start), .conv_enable(conv_enable),
    .conv_done(conv_done), .conv_result(conv_result), .res_12b(res_12b),
    .irq_pulse(irq_pulse), .upper_lim(upper_lim), .lower_lim(lower_lim),
    .mode(mode), .wr_err(wr_err)
);

// File: tb/adc_window_cmp_bench.sv
// Bench: directed corners plus seeded random conversions, checked against a
// bench-side model of the register map and the window rule.
module adc_window_cmp_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        conv_start = 1'b0, conv_enable = 1'b0, conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic        res_12b = 1'b1;
    logic        irq_pulse;

    int errors = 0;
    int checks = 0;
    logic [7:0] m_up = 8'hFF, m_lo = 8'h00;
    logic       m_mode = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_window_cmp u_adc_window_cmp (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .conv_start(conv_start), .conv_enable(conv_enable),
        .conv_done(conv_done), .conv_result(conv_result), .res_12b(res_12b),
        .irq_pulse(irq_pulse)
    );

    function automatic logic exp_hit(logic md, logic [7:0] up, logic [7:0] lo,
                                     logic [11:0] r, logic full);
        logic [7:0] v;
        v = full ? r[11:4] : r[7:0];
        if (md) return (v < lo) || (v > up);
        return (v >= lo) && (v <= up);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic convert(string req, logic [11:0] r, logic full);
        logic e;
        e = exp_hit(m_mode, m_up, m_lo, r, full);
        @(negedge clk);
        conv_done = 1'b1; conv_result = r; res_12b = full;
        #1 check({req, " no early irq"}, {7'd0, irq_pulse}, 8'd0);
        @(negedge clk);
        conv_done = 1'b0;
        check(req, {7'd0, irq_pulse}, {7'd0, e});
        @(negedge clk);
        check({req, " R9 single cycle"}, {7'd0, irq_pulse}, 8'd0);
    endtask

    task automatic set_lim(logic [7:0] up, logic [7:0] lo);
        wr(2'd0, up); wr(2'd1, lo);
        m_up = up; m_lo = lo;
    endtask

    task automatic set_mode(logic md);
        wr(2'd2, {7'd0, md});
        m_mode = md;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 irq", {7'd0, irq_pulse}, 8'd0);
        rd(2'd0, d); check("R1 upper", d, 8'hFF);
        rd(2'd1, d); check("R1 lower", d, 8'h00);
        rd(2'd2, d); check("R1 mode", d, 8'h00);
        rd(2'd3, d); check("R1 err", d, 8'h00);
        convert("R1 reset window passes all", 12'h000, 1'b1);
        convert("R1 reset window passes top", 12'hFFF, 1'b1);

        // R2 accepted writes
        set_lim(8'hA0, 8'h40);
        rd(2'd0, d); check("R2 upper", d, 8'hA0);
        rd(2'd1, d); check("R2 lower", d, 8'h40);

        // R3 / R4 refused writes with start, then with enable
        conv_start = 1'b1;
        wr(2'd0, 8'h11);
        conv_start = 1'b0;
        rd(2'd0, d); check("R3 upper unchanged", d, 8'hA0);
        conv_enable = 1'b1;
        wr(2'd1, 8'h22);
        // R11 mode write accepted while busy
        set_mode(1'b1);
        conv_enable = 1'b0;
        rd(2'd1, d); check("R3 lower unchanged", d, 8'h40);
        rd(2'd2, d); check("R11 mode while busy", d, 8'h01);
        rd(2'd3, d); check("R4 err set", d, 8'h01);
        rd(2'd3, d); check("R4 err cleared by read", d, 8'h00);
        set_mode(1'b0);

        // R5 / R7 boundaries at 12 bits: top byte only
        convert("R5 R7 at lower", 12'h40F, 1'b1);
        convert("R5 R7 below lower", 12'h3FF, 1'b1);
        convert("R5 R7 at upper", 12'hA0F, 1'b1);
        convert("R5 R7 above upper", 12'hA10, 1'b1);
        // R6 low byte at 8 bits, upper nibble ignored
        convert("R6 in window", 12'hF50, 1'b0);
        convert("R6 out of window", 12'h0A1, 1'b0);
        // R8 outside mode
        set_mode(1'b1);
        convert("R8 below lower", 12'h3F0, 1'b1);
        convert("R8 at lower", 12'h400, 1'b1);
        convert("R8 above upper", 12'h0A1, 1'b0);
        // R10 inverted limits
        set_lim(8'h20, 8'h80);
        convert("R10 outside between", 12'h050, 1'b0);
        convert("R10 outside low", 12'h010, 1'b0);
        set_mode(1'b0);
        convert("R10 inside never", 12'h050, 1'b0);
        convert("R10 inside never at bound", 12'h800, 1'b1);

        // Seeded random mix
        for (int i = 0; i < 400; i++) begin
            if (i % 16 == 0) begin
                set_lim(8'($urandom), 8'($urandom));
                set_mode(1'($urandom));
            end
            if (i % 37 == 0) begin
                conv_enable = 1'b1;
                wr(2'($urandom_range(0, 1)), 8'($urandom));
                conv_enable = 1'b0;
                rd(2'd3, d); check("R4 random refusal", d, 8'h01);
                rd(2'd0, d); check("R3 random upper kept", d, m_up);
                rd(2'd1, d); check("R3 random lower kept", d, m_lo);
            end
            convert("R7 R8 random", 12'($urandom), 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule